// File: doc/BRIEF.md
# PTP Event Timestamp Capture Unit

This unit sits beside the receive and transmit byte streams of a small group of switch ports. Every frame whose EtherType is 0x88F7 and whose PTP message type lies in the event range (0 to 3) is timestamped. The time is the time-of-day value present on the cycle the first byte of the frame was seen. Together with that time, the unit keeps four header bytes that let software pair a timestamp with its frame: the message-type byte, the domain byte and the two sequence-identifier bytes. Each port and direction has its own capture queue, four entries deep by default.

Software works through a 16-bit register window. It writes a command naming a port and a direction, with the transfer flag set. The controller then has two states. `ST_IDLE` leaves for `ST_FETCH` when a command with the transfer flag arrives. `ST_FETCH` returns to `ST_IDLE` after one cycle, always. In that cycle it loads the oldest capture of the chosen queue into the shared read-back registers, removes that capture from the queue and drops the transfer flag. Pending-status bits show which queues hold data. A level interrupt stays raised while any transmit queue is not empty, so a handler can drain several captures per port in one pass.

Top module: `ptp_ts_cap`

## Requirements
- R1: A capture is made only when frame bytes 12 and 13 are 0x88 and 0xF7, the low nibble of byte 14 is 3 or less, and the frame reaches byte 45. Any other frame leaves every queue unchanged.
- R2: Time read-back: offset 0x08 returns nanoseconds bits 15:0. Offset 0x0A returns the 2-bit seconds in bits 15:14 and nanoseconds bits 29:16 in bits 13:0. Both are sampled on the clock edge that takes in the frame's first byte (start marker with valid).
- R3: Header read-back: offset 0x0C returns {byte 18, byte 14}. Offset 0x0E returns {byte 44, byte 45}. These are header bytes 4 and 0, then the sequence identifier bytes 30 and 31.
- R4: Command register at offset 0x00. Bits 3:0 hold the port, bit 4 selects the direction (1 receive, 0 transmit) and bit 14 requests a transfer. After the write, bit 14 reads 1 for one cycle, then 0, and the read-back registers then hold the result.
- R5: Each queue returns its captures oldest first, and one transfer removes exactly one entry.
- R6: Offset 0x10 (receive) and offset 0x12 (transmit) hold bit p = 1 exactly while port p's queue in that direction is not empty.
- R7: A transfer to an empty queue, or to a port number outside the port count, still completes and loads all-zero read-back data.
- R8: A capture arriving at a full queue is dropped. It sets a sticky flag at offset 0x14: receive port p in bit p, transmit port p in bit 8+p. The flag stays set until reset.
- R9: `irq` is high exactly while any transmit queue holds a capture.
- R10: After reset all queues are empty, all registers read zero and `irq` is low.
- R11: A command written while a transfer is in progress is ignored. The port and direction it names are not latched and its queue is not popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | NPORTS | Receive byte valid, one bit per port |
| rx_sof | input | NPORTS | Receive first-byte marker, per port |
| rx_data | input | 8*NPORTS | Receive bytes, port p in bits 8p+7:8p |
| tx_valid | input | NPORTS | Transmit byte valid, one bit per port |
| tx_sof | input | NPORTS | Transmit first-byte marker, per port |
| tx_data | input | 8*NPORTS | Transmit bytes, port p in bits 8p+7:8p |
| tod_sec | input | 2 | Time-of-day seconds, low two bits |
| tod_ns | input | 30 | Time-of-day nanoseconds |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from reg_addr) |
| irq | output | 1 | Transmit capture pending interrupt |

## Verification
The assertions take three things for granted. A queue entry leaves only through a transfer. Streams mark each frame's first byte with the start flag while valid is high. The port count is at most eight, so the overflow word has room. The bench sends frames one stream at a time and issues commands only between frames, so a push and a pop never meet in the same cycle. Random frames mix wrong EtherTypes, message types above 3, short lengths and idle gaps in the valid signal. Directed cases cover full queues, out-of-range ports and a command written during a busy cycle.

// File: rtl/ptp_ts_pkg.sv
package ptp_ts_pkg;

    localparam logic [15:0] PTP_ETYPE   = 16'h88F7;
    localparam int          PORT_FLD_W  = 4;
    localparam int          MAX_MSG_EVT = 3;

    // frame byte positions the classifier inspects
    localparam int POS_ETYPE_HI = 12;
    localparam int POS_ETYPE_LO = 13;
    localparam int POS_MSGTYPE  = 14;
    localparam int POS_DOMAIN   = 18;
    localparam int POS_SEQ_HI   = 44;
    localparam int POS_SEQ_LO   = 45;

    // register offsets
    localparam logic [7:0] OFS_CMD  = 8'h00;
    localparam logic [7:0] OFS_TLO  = 8'h08;
    localparam logic [7:0] OFS_THI  = 8'h0A;
    localparam logic [7:0] OFS_HW0  = 8'h0C;
    localparam logic [7:0] OFS_HW1  = 8'h0E;
    localparam logic [7:0] OFS_RXST = 8'h10;
    localparam logic [7:0] OFS_TXST = 8'h12;
    localparam logic [7:0] OFS_OVF  = 8'h14;

    localparam int CMD_DIR_BIT  = 4;
    localparam int CMD_XFER_BIT = 14;

    typedef struct packed {
        logic [1:0]  sec;
        logic [29:0] ns;
        logic [15:0] hw0;
        logic [15:0] hw1;
    } ts_entry_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } xfer_state_t;

endpackage

// File: rtl/ptp_ts_classifier.sv
module ptp_ts_classifier
    import ptp_ts_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic [7:0]  in_data,
    input  logic [1:0]  tod_sec,
    input  logic [29:0] tod_ns,
    output logic        push,
    output ts_entry_t   entry
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] pos_q;
    logic [CNT_W-1:0] idx;
    logic             match_q;
    logic [1:0]       sec_q;
    logic [29:0]      ns_q;
    logic [7:0]       msg_q, dom_q, seqhi_q;

    assign idx = (in_valid && in_sof) ? '0 : pos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q   <= CNT_MAX;
            match_q <= 1'b0;
            sec_q   <= '0;
            ns_q    <= '0;
            msg_q   <= '0;
            dom_q   <= '0;
            seqhi_q <= '0;
        end else if (in_valid) begin
            if (idx != CNT_MAX) pos_q <= idx + 1'b1;
            if (in_sof) begin
                match_q <= 1'b1;
                sec_q   <= tod_sec;
                ns_q    <= tod_ns;
            end
            if (idx == CNT_W'(POS_ETYPE_HI) && in_data != PTP_ETYPE[15:8]) match_q <= 1'b0;
            if (idx == CNT_W'(POS_ETYPE_LO) && in_data != PTP_ETYPE[7:0])  match_q <= 1'b0;
            if (idx == CNT_W'(POS_MSGTYPE)) begin
                msg_q <= in_data;
                if (in_data[3:0] > 4'(MAX_MSG_EVT)) match_q <= 1'b0;
            end
            if (idx == CNT_W'(POS_DOMAIN)) dom_q   <= in_data;
            if (idx == CNT_W'(POS_SEQ_HI)) seqhi_q <= in_data;
        end
    end

    assign push  = in_valid && match_q && (idx == CNT_W'(POS_SEQ_LO));
    assign entry = '{sec: sec_q, ns: ns_q, hw0: {dom_q, msg_q}, hw1: {seqhi_q, in_data}};

endmodule

// File: rtl/ptp_ts_fifo.sv
module ptp_ts_fifo
    import ptp_ts_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  ts_entry_t din,
    input  logic      pop,
    output ts_entry_t dout,
    output logic      empty,
    output logic      ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    ts_entry_t       mem [DEPTH];
    logic [AW-1:0]   rd_q, wr_q;
    logic [CW-1:0]   cnt_q;
    logic            full, do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt_q == CW'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_push) wr_q <= nxt(wr_q);
            if (do_pop)  rd_q <= nxt(rd_q);
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
            if (push && full) ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/ptp_ts_cap.sv
module ptp_ts_cap
    import ptp_ts_pkg::*;
#(
    parameter int NPORTS = 4,   // at most 8: overflow word packs both directions
    parameter int DEPTH  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPORTS-1:0]     rx_valid,
    input  logic [NPORTS-1:0]     rx_sof,
    input  logic [8*NPORTS-1:0]   rx_data,
    input  logic [NPORTS-1:0]     tx_valid,
    input  logic [NPORTS-1:0]     tx_sof,
    input  logic [8*NPORTS-1:0]   tx_data,
    input  logic [1:0]            tod_sec,
    input  logic [29:0]           tod_ns,
    input  logic                  reg_wr,
    input  logic [7:0]            reg_addr,
    input  logic [15:0]           reg_wdata,
    output logic [15:0]           reg_rdata,
    output logic                  irq
);
    // stream s < NPORTS is transmit port s, stream s >= NPORTS is receive port s-NPORTS
    localparam int NSTREAM = 2 * NPORTS;

    ts_entry_t           cap   [NSTREAM];
    ts_entry_t           head  [NSTREAM];
    logic [NSTREAM-1:0]  push_v, pop_v, empty_v, ovf_v;

    for (genvar s = 0; s < NSTREAM; s++) begin : g_stream
        localparam int P = s % NPORTS;
        logic       v, sf;
        logic [7:0] d;
        if (s >= NPORTS) begin : g_rx
            assign v  = rx_valid[P];
            assign sf = rx_sof[P];
            assign d  = rx_data[8*P +: 8];
        end else begin : g_tx
            assign v  = tx_valid[P];
            assign sf = tx_sof[P];
            assign d  = tx_data[8*P +: 8];
        end
        ptp_ts_classifier u_cls (
            .clk(clk), .rst_n(rst_n), .in_valid(v), .in_sof(sf), .in_data(d),
            .tod_sec(tod_sec), .tod_ns(tod_ns), .push(push_v[s]), .entry(cap[s])
        );
        ptp_ts_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk(clk), .rst_n(rst_n), .push(push_v[s]), .din(cap[s]),
            .pop(pop_v[s]), .dout(head[s]), .empty(empty_v[s]), .ovf(ovf_v[s])
        );
    end

    xfer_state_t           state_q, state_d;
    logic [PORT_FLD_W-1:0] port_q;
    logic                  dir_q;
    logic                  start, pop_en, busy, cmd_hit;
    ts_entry_t             rb_q, sel_entry;
    logic [NPORTS-1:0]     rx_pend, tx_pend;
    logic [15:0]           ovf_word;

    assign cmd_hit = reg_wr && (reg_addr == OFS_CMD) && reg_wdata[CMD_XFER_BIT];
    assign busy    = (state_q == ST_FETCH);

    // state register, command latch and read-back load
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            port_q  <= '0;
            dir_q   <= 1'b0;
            rb_q    <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                port_q <= reg_wdata[PORT_FLD_W-1:0];
                dir_q  <= reg_wdata[CMD_DIR_BIT];
            end
            if (pop_en) rb_q <= sel_entry;
        end
    end

    // next state and control outputs
    always_comb begin
        state_d = state_q;
        start   = 1'b0;
        pop_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_hit) begin
                    start   = 1'b1;
                    state_d = ST_FETCH;
                end
            end
            ST_FETCH: begin
                pop_en  = 1'b1;
                state_d = ST_IDLE;
            end
        endcase
    end

    // queue selection for the transfer in progress
    always_comb begin
        sel_entry = '0;
        pop_v     = '0;
        for (int s = 0; s < NSTREAM; s++) begin
            if (int'(port_q) < NPORTS &&
                s == int'(dir_q) * NPORTS + int'(port_q)) begin
                if (!empty_v[s]) sel_entry = head[s];
                pop_v[s] = pop_en;
            end
        end
    end

    always_comb begin
        ovf_word = '0;
        for (int p = 0; p < NPORTS; p++) begin
            tx_pend[p]      = !empty_v[p];
            rx_pend[p]      = !empty_v[NPORTS + p];
            ovf_word[p]     = ovf_v[NPORTS + p];
            ovf_word[8 + p] = ovf_v[p];
        end
    end

    assign irq = |tx_pend;

    always_comb begin
        case (reg_addr)
            OFS_CMD:  reg_rdata = {1'b0, busy, 9'b0, dir_q, port_q};
            OFS_TLO:  reg_rdata = rb_q.ns[15:0];
            OFS_THI:  reg_rdata = {rb_q.sec, rb_q.ns[29:16]};
            OFS_HW0:  reg_rdata = rb_q.hw0;
            OFS_HW1:  reg_rdata = rb_q.hw1;
            OFS_RXST: reg_rdata = 16'(rx_pend);
            OFS_TXST: reg_rdata = 16'(tx_pend);
            OFS_OVF:  reg_rdata = ovf_word;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ptp_ts_cap_chk.sv
module ptp_ts_cap_chk #(
    parameter int NPORTS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic [NPORTS-1:0] rx_pend,
    input logic [NPORTS-1:0] tx_pend,
    input logic [15:0]       ovf_word,
    input logic              irq,
    input logic [15:0]       rb_lo
);

    assert_xfer_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    assert_readback_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy) |-> $stable(rb_lo));

    assert_rx_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(rx_pend) & ~rx_pend)) |-> $past(busy));

    assert_tx_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(tx_pend) & ~tx_pend)) |-> $past(busy));

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf_word & $past(ovf_word)) == $past(ovf_word)));

    assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(busy));

endmodule

bind ptp_ts_cap ptp_ts_cap_chk #(.NPORTS(NPORTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .rx_pend(rx_pend), .tx_pend(tx_pend),
    .ovf_word(ovf_word), .irq(irq), .rb_lo(rb_q.ns[15:0])
);

// File: tb/ptp_ts_cap_tb.sv
`timescale 1ns/1ps
module ptp_ts_cap_tb;
    localparam int NP = 4;
    localparam int DP = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     rx_valid = '0, rx_sof = '0, tx_valid = '0, tx_sof = '0;
    logic [8*NP-1:0]   rx_data = '0, tx_data = '0;
    logic [1:0]        tod_sec = '0;
    logic [29:0]       tod_ns = 30'd999_000_000;
    logic              reg_wr = 1'b0;
    logic [7:0]        reg_addr = '0;
    logic [15:0]       reg_wdata = '0;
    logic [15:0]       reg_rdata;
    logic              irq;

    int checks = 0;
    int errors = 0;

    logic [63:0] mq   [2*NP][DP];
    int          mcnt [2*NP];
    logic        movf [2*NP];

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        logic [31:0] nx;
        nx = {2'b0, tod_ns} + 32'd4099;
        if (nx >= 32'd1_000_000_000) begin
            tod_ns  <= 30'(nx - 32'd1_000_000_000);
            tod_sec <= tod_sec + 2'd1;
        end else begin
            tod_ns <= nx[29:0];
        end
    end

    ptp_ts_cap #(.NPORTS(NP), .DEPTH(DP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_sof(tx_sof), .tx_data(tx_data),
        .tod_sec(tod_sec), .tod_ns(tod_ns),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input int i, input logic [15:0] et, input logic [3:0] mt,
                                         input logic [15:0] seq, input logic [7:0] tag);
        case (i)
            12:      return et[15:8];
            13:      return et[7:0];
            14:      return {tag[7:4], mt};
            18:      return tag ^ 8'h5A;
            44:      return seq[15:8];
            45:      return seq[7:0];
            default: return 8'(i) ^ tag;
        endcase
    endfunction

    task automatic idle_streams();
        rx_valid = '0; rx_sof = '0; tx_valid = '0; tx_sof = '0;
    endtask

    task automatic send(input int dir, input int port, input logic [15:0] et, input logic [3:0] mt,
                        input logic [15:0] seq, input int len, input logic [7:0] tag, input bit gaps);
        logic [1:0]  s_sec = '0;
        logic [29:0] s_ns = '0;
        int st = dir * NP + port;
        for (int i = 0; i < len; i++) begin
            if (gaps && i > 0 && $urandom_range(0, 3) == 0) begin
                @(negedge clk); idle_streams();
            end
            @(negedge clk);
            idle_streams();
            if (dir == 1) begin
                rx_valid[port] = 1'b1; rx_sof[port] = (i == 0);
                rx_data[8*port +: 8] = fbyte(i, et, mt, seq, tag);
            end else begin
                tx_valid[port] = 1'b1; tx_sof[port] = (i == 0);
                tx_data[8*port +: 8] = fbyte(i, et, mt, seq, tag);
            end
            if (i == 0) begin
                #1; s_sec = tod_sec; s_ns = tod_ns;
            end
        end
        @(negedge clk); idle_streams();
        // R1: model keeps only event frames with the right type that reach byte 45
        if (et == 16'h88F7 && mt <= 4'd3 && len >= 46) begin
            if (mcnt[st] < DP) begin
                mq[st][mcnt[st]] = {s_sec, s_ns, tag ^ 8'h5A, tag[7:4], mt, seq};
                mcnt[st]++;
            end else begin
                movf[st] = 1'b1;
            end
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    function automatic logic [63:0] model_pop(input int dir, input int port);
        logic [63:0] e = '0;
        int st = dir * NP + port;
        if (port < NP && mcnt[st] > 0) begin
            e = mq[st][0];
            for (int k = 0; k < DP - 1; k++) mq[st][k] = mq[st][k+1];
            mcnt[st]--;
        end
        return e;
    endfunction

    task automatic read_back(input int dir, input int port, input logic [63:0] exp);
        logic [15:0] lo, hi, h0, h1;
        bit empty_case;
        empty_case = (port >= NP) || (exp == 64'd0);
        rd(8'h08, lo); rd(8'h0A, hi); rd(8'h0C, h0); rd(8'h0E, h1);
        if (empty_case)
            chk({hi, lo, h0, h1} == 64'd0, "R7 empty transfer data", {hi, lo, h0, h1}, 64'd0);
        else begin
            chk({hi, lo} == exp[63:32], "R2 R5 time read-back", {32'd0, hi, lo}, {32'd0, exp[63:32]});
            chk({h0, h1} == exp[31:0], "R3 R5 header read-back", {32'd0, h0, h1}, {32'd0, exp[31:0]});
        end
    endtask

    task automatic xfer(input int dir, input int port);
        logic [63:0] exp;
        @(negedge clk);
        reg_addr  = 8'h00;
        reg_wdata = 16'(32'h4000 | (dir << 4) | (port & 15));
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        #1 chk(reg_rdata[14] == 1'b1, "R4 transfer bit set", 64'(reg_rdata), 64'h4000);
        @(negedge clk);
        #1 chk(reg_rdata[14] == 1'b0, "R4 transfer bit cleared", 64'(reg_rdata[14]), 64'd0);
        exp = model_pop(dir, port);
        read_back(dir, port, exp);
    endtask

    task automatic check_status();
        logic [15:0] rxs, txs, ovw, erx, etx, eov;
        erx = '0; etx = '0; eov = '0;
        for (int p = 0; p < NP; p++) begin
            erx[p] = (mcnt[NP + p] > 0);
            etx[p] = (mcnt[p] > 0);
            eov[p] = movf[NP + p];
            eov[8 + p] = movf[p];
        end
        rd(8'h10, rxs); rd(8'h12, txs);
        chk(rxs == erx, "R6 receive status", 64'(rxs), 64'(erx));
        chk(txs == etx, "R6 transmit status", 64'(txs), 64'(etx));
        chk(irq == (etx != 0), "R9 interrupt level", 64'(irq), 64'(etx != 0));
        rd(8'h14, ovw);
        chk(ovw == eov, "R8 overflow flags", 64'(ovw), 64'(eov));
    endtask

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog R4 actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd2718));
        for (int s = 0; s < 2*NP; s++) begin mcnt[s] = 0; movf[s] = 1'b0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state
        foreach (v[i]) ;
        for (int a = 0; a <= 8'h14; a += 2) begin
            rd(8'(a), v);
            chk(v == 16'd0, "R10 register after reset", 64'(v), 64'd0);
        end
        chk(irq == 1'b0, "R10 interrupt after reset", 64'(irq), 64'd0);

        // R1: frames that must be ignored
        send(1, 1, 16'h0800, 4'd0, 16'h1111, 50, 8'h21, 1'b0);
        send(0, 2, 16'h88F7, 4'd4, 16'h2222, 50, 8'h32, 1'b0);
        send(1, 0, 16'h88F7, 4'd1, 16'h3333, 45, 8'h43, 1'b0);
        send(0, 3, 16'h88F6, 4'd2, 16'h4444, 60, 8'h54, 1'b0);
        rd(8'h10, v); chk(v == 16'd0, "R1 rejected receive frames", 64'(v), 64'd0);
        rd(8'h12, v); chk(v == 16'd0, "R1 rejected transmit frames", 64'(v), 64'd0);

        // accepted transmit frame, boundary message type 3
        send(0, 3, 16'h88F7, 4'd3, 16'hBEEF, 46, 8'hC7, 1'b1);
        check_status();
        xfer(0, 3);
        check_status();

        // R7: empty queue and out-of-range port
        xfer(1, 2);
        xfer(1, 9);

        // R8 and R5: five frames into a four-deep queue
        for (int k = 0; k < 5; k++)
            send(1, 1, 16'h88F7, 4'(k % 4), 16'(16'h0100 + k), 48, 8'(8'h10 * k + 3), 1'b0);
        check_status();
        for (int k = 0; k < 5; k++) xfer(1, 1);
        check_status();

        // R11: second command while busy is ignored
        send(0, 0, 16'h88F7, 4'd0, 16'hA0A0, 50, 8'h66, 1'b0);
        send(1, 3, 16'h88F7, 4'd2, 16'hB0B0, 50, 8'h77, 1'b0);
        @(negedge clk);
        reg_addr = 8'h00; reg_wdata = 16'h4000; reg_wr = 1'b1;
        @(negedge clk);
        reg_wdata = 16'h4013;
        @(negedge clk);
        reg_wr = 1'b0;
        #1 chk(reg_rdata[4:0] == 5'd0, "R11 busy command not latched", 64'(reg_rdata[4:0]), 64'd0);
        read_back(0, 0, model_pop(0, 0));
        rd(8'h10, v);
        chk(v[3] == 1'b1, "R11 queue of ignored command untouched", 64'(v[3]), 64'd1);
        xfer(1, 3);
        check_status();

        // random traffic mixed with transfers
        for (int it = 0; it < 300; it++) begin
            int d, p;
            d = $urandom_range(0, 1);
            p = $urandom_range(0, NP - 1);
            send(d, p, ($urandom_range(0, 7) == 0) ? 16'h0800 : 16'h88F7,
                 4'($urandom_range(0, 7)), 16'($urandom), $urandom_range(40, 60),
                 8'($urandom), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 2) == 0)
                xfer($urandom_range(0, 1), $urandom_range(0, NP + 1));
            if (it % 25 == 0) check_status();
        end

        // drain everything
        for (int s = 0; s < 2*NP; s++)
            while (mcnt[s] > 0) xfer(s / NP, s % NP);
        check_status();

        summary();
        $finish;
    end

endmodule